// File: doc/BRIEF.md
# Asymmetric Dual-Issue Instruction Dispatcher

This block sits between the decode stage and the execution pipes of an in-order core that has one integer pipe and one floating-point compute pipe. Each cycle it receives the two oldest decoded instructions, called the old slot and the young slot. For each slot it decides whether the instruction can leave this cycle. It then tells the fetch buffer how many entries to retire: zero, one or two.

The two pipes are not interchangeable. The integer pipe takes ALU work, branches and every load or store, including loads and stores that move floating-point registers. The floating-point pipe takes only arithmetic and conversions. A pair can therefore leave together only when one instruction belongs to each pipe. Issue keeps program order, so the young slot can never leave ahead of the old one.

Two checks hold back instructions with data hazards. The first compares the register fields of the two slots within the pair. The second is a scoreboard with one bit per floating-point register. The bit is set when an instruction that writes that register issues, and cleared by a writeback report from the floating-point side. A downstream stall input freezes issue while the slots keep their contents.

Top module: `dual_dispatch`

## Requirements
- R1: After reset, no floating-point register is marked pending, so an instruction that reads or writes any floating-point register is not held by the scoreboard. With both slots invalid, nothing issues and `consumed` is 0.
- R2: Class codes are 0 for ALU or branch, 1 for a load or store (integer or floating-point register), 2 for floating-point arithmetic and 3 for floating-point conversion. Codes 0 and 1 go to the integer pipe and codes 2 and 3 go to the floating-point pipe. `int_go` is high exactly when an issued slot is integer-pipe. `fp_go` is high exactly when an issued slot is floating-point-pipe.
- R3: Two instructions bound for the same pipe never issue in one cycle. In that case only the old slot issues.
- R4: The young slot issues only when the old slot issues in the same cycle. An invalid or blocked old slot holds the young one.
- R5: The young slot is blocked when one of its enabled sources names the register the old slot writes. A match needs the same file (the `_fp` flag) and the same index. Integer register 0 never matches.
- R6: The young slot is blocked when it writes the same register (same file and index) as the old slot, with integer register 0 excepted.
- R7: Issuing an instruction that writes a floating-point register marks that register pending from the next cycle. An instruction that reads or writes a pending floating-point register does not issue.
- R8: A writeback report (`wb_valid`, `wb_reg`) clears the pending mark from the next cycle. If the same register is marked by an issue in the same cycle, it stays pending.
- R9: While `stall` is high, neither slot issues and the scoreboard is left unchanged, apart from writeback clears.
- R10: `consumed` equals the number of slots issued this cycle: 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Downstream hold; suppresses all issue |
| s0_valid | input | 1 | Old slot holds an instruction |
| s0_cls | input | 2 | Old slot class code |
| s0_wr_en | input | 1 | Old slot writes a register |
| s0_wr_fp | input | 1 | Old slot destination is floating-point |
| s0_wr_reg | input | REG_W | Old slot destination index |
| s0_rd_en | input | SRC_N | Old slot source enables |
| s0_rd_fp | input | SRC_N | Old slot source file flags |
| s0_rd_reg | input | SRC_N*REG_W | Old slot source indices, source 0 in the low bits |
| s1_valid | input | 1 | Young slot holds an instruction |
| s1_cls | input | 2 | Young slot class code |
| s1_wr_en | input | 1 | Young slot writes a register |
| s1_wr_fp | input | 1 | Young slot destination is floating-point |
| s1_wr_reg | input | REG_W | Young slot destination index |
| s1_rd_en | input | SRC_N | Young slot source enables |
| s1_rd_fp | input | SRC_N | Young slot source file flags |
| s1_rd_reg | input | SRC_N*REG_W | Young slot source indices |
| wb_valid | input | 1 | Floating-point result written back |
| wb_reg | input | REG_W | Floating-point register written back |
| issue_old | output | 1 | Old slot issues this cycle |
| issue_young | output | 1 | Young slot issues this cycle |
| int_go | output | 1 | An instruction enters the integer pipe |
| fp_go | output | 1 | An instruction enters the floating-point pipe |
| consumed | output | 2 | Number of slots issued |

## Verification
The assertions assume the slot fields are settled before the clock edge. They also assume a writeback names a register the floating-point side really owes, though a writeback for a register that is not pending does no harm. The stimulus draws every register index from a narrow window of eight. This makes same-pair matches, pending reads and writeback races frequent, and it keeps the scoreboard from filling and starving issue. Stall and writeback are drawn at moderate rates so that every hazard path keeps being reached. Directed pairs cover integer register 0, same-pipe pairs, the set-versus-clear race and clearing by reset.

// File: rtl/disp_pkg.sv
// Shared class codes and pipe mapping for the dual-issue dispatcher.
// Assumes the class code is two bits wide.
package disp_pkg;
    typedef enum logic [1:0] {
        CLS_ALU      = 2'd0,
        CLS_MEM      = 2'd1,
        CLS_FP_ARITH = 2'd2,
        CLS_FP_CONV  = 2'd3
    } instr_cls_e;

    localparam int CLS_W = 2;

    // True when the class is bound for the floating-point compute pipe.
    function automatic logic goes_fp_pipe(input logic [CLS_W-1:0] cls);
        return (cls == CLS_FP_ARITH) || (cls == CLS_FP_CONV);
    endfunction
endpackage

// File: rtl/disp_scoreboard.sv
// Pending-write scoreboard: one bit per floating-point register.
// Assumes at most SET_N marks and one clear per cycle; a mark wins over
// a clear of the same register in the same cycle.
module disp_scoreboard #(
    parameter int REG_W = 5,
    parameter int SET_N = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SET_N-1:0]        set_en,
    input  logic [SET_N*REG_W-1:0]  set_reg,
    input  logic                    clr_en,
    input  logic [REG_W-1:0]        clr_reg,
    output logic [(1<<REG_W)-1:0]   pending
);
    localparam int NREG = 1 << REG_W;

    logic [NREG-1:0] set_mask;
    logic [NREG-1:0] clr_mask;

    // Decode the mark and clear requests into register masks.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int r = 0; r < NREG; r++) begin
            for (int s = 0; s < SET_N; s++) begin
                if (set_en[s] && set_reg[s*REG_W +: REG_W] == REG_W'(r))
                    set_mask[r] = 1'b1;
            end
            if (clr_en && clr_reg == REG_W'(r))
                clr_mask[r] = 1'b1;
        end
    end

    // Hold the pending bits; reset empties the board.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= '0;
        else
            pending <= (pending & ~clr_mask) | set_mask;
    end

    // R7
    mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en[0] |=> pending[$past(set_reg[REG_W-1:0])]);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && !(set_en[0] && set_reg[REG_W-1:0] == clr_reg)
               && !(set_en[SET_N-1] && set_reg[(SET_N-1)*REG_W +: REG_W] == clr_reg)
        |=> !pending[$past(clr_reg)]);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en == '0) && !clr_en |=> $stable(pending));
endmodule

// File: rtl/disp_slot_chk.sv
// Per-slot scoreboard lookup: flags a slot whose floating-point sources or
// floating-point destination are still pending. Purely combinational.
module disp_slot_chk #(
    parameter int REG_W = 5,
    parameter int SRC_N = 2
) (
    input  logic [(1<<REG_W)-1:0]   pending,
    input  logic                    wr_en,
    input  logic                    wr_fp,
    input  logic [REG_W-1:0]        wr_reg,
    input  logic [SRC_N-1:0]        rd_en,
    input  logic [SRC_N-1:0]        rd_fp,
    input  logic [SRC_N*REG_W-1:0]  rd_reg,
    output logic                    sb_hit
);
    logic [SRC_N-1:0] src_hit;

    // One lookup per source operand.
    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        assign src_hit[g] = rd_en[g] && rd_fp[g] && pending[rd_reg[g*REG_W +: REG_W]];
    end

    // Combine source and destination hits.
    assign sb_hit = (|src_hit) || (wr_en && wr_fp && pending[wr_reg]);
endmodule

// File: rtl/disp_pair_chk.sv
// Same-pair dependency check: flags a young slot that reads or rewrites the
// register the old slot writes. Integer register 0 is hardwired and never
// creates a dependency.
module disp_pair_chk #(
    parameter int REG_W = 5,
    parameter int SRC_N = 2
) (
    input  logic                    old_wr_en,
    input  logic                    old_wr_fp,
    input  logic [REG_W-1:0]        old_wr_reg,
    input  logic                    yng_wr_en,
    input  logic                    yng_wr_fp,
    input  logic [REG_W-1:0]        yng_wr_reg,
    input  logic [SRC_N-1:0]        yng_rd_en,
    input  logic [SRC_N-1:0]        yng_rd_fp,
    input  logic [SRC_N*REG_W-1:0]  yng_rd_reg,
    output logic                    raw_dep,
    output logic                    waw_dep
);
    // Same file, same index, and not the hardwired zero register.
    function automatic logic same_reg(input logic fa, input logic [REG_W-1:0] ra,
                                      input logic fb, input logic [REG_W-1:0] rb);
        return (fa == fb) && (ra == rb) && (fa || ra != '0);
    endfunction

    logic [SRC_N-1:0] src_dep;

    // Compare each young source against the old destination.
    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        assign src_dep[g] = yng_rd_en[g] &&
            same_reg(old_wr_fp, old_wr_reg, yng_rd_fp[g], yng_rd_reg[g*REG_W +: REG_W]);
    end

    // Read-after-write and write-after-write within the pair.
    assign raw_dep = old_wr_en && (|src_dep);
    assign waw_dep = old_wr_en && yng_wr_en &&
                     same_reg(old_wr_fp, old_wr_reg, yng_wr_fp, yng_wr_reg);
endmodule

// File: rtl/dual_dispatch.sv
// Asymmetric dual-issue dispatcher. Grants the old slot when it is valid,
// not stalled and clear of the scoreboard; grants the young slot only
// alongside the old one, on the other pipe, and free of hazards.
// Assumes slot fields are stable before the clock edge.
module dual_dispatch
    import disp_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int SRC_N = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stall,
    input  logic                    s0_valid,
    input  logic [1:0]              s0_cls,
    input  logic                    s0_wr_en,
    input  logic                    s0_wr_fp,
    input  logic [REG_W-1:0]        s0_wr_reg,
    input  logic [SRC_N-1:0]        s0_rd_en,
    input  logic [SRC_N-1:0]        s0_rd_fp,
    input  logic [SRC_N*REG_W-1:0]  s0_rd_reg,
    input  logic                    s1_valid,
    input  logic [1:0]              s1_cls,
    input  logic                    s1_wr_en,
    input  logic                    s1_wr_fp,
    input  logic [REG_W-1:0]        s1_wr_reg,
    input  logic [SRC_N-1:0]        s1_rd_en,
    input  logic [SRC_N-1:0]        s1_rd_fp,
    input  logic [SRC_N*REG_W-1:0]  s1_rd_reg,
    input  logic                    wb_valid,
    input  logic [REG_W-1:0]        wb_reg,
    output logic                    issue_old,
    output logic                    issue_young,
    output logic                    int_go,
    output logic                    fp_go,
    output logic [1:0]              consumed
);
    localparam int NREG   = 1 << REG_W;
    localparam int SLOT_N = 2;

    logic [NREG-1:0]          pending;
    logic [SLOT_N-1:0]        sb_hit;
    logic [SLOT_N-1:0]        wr_en_v, wr_fp_v;
    logic [SLOT_N*REG_W-1:0]  wr_reg_v;
    logic [SRC_N-1:0]         rd_en_a  [SLOT_N];
    logic [SRC_N-1:0]         rd_fp_a  [SLOT_N];
    logic [SRC_N*REG_W-1:0]   rd_reg_a [SLOT_N];
    logic                     raw_dep, waw_dep;
    logic                     fp0, fp1;
    logic [SLOT_N-1:0]        mark_en;

    // Gather slot fields into arrays for the per-slot checks.
    assign wr_en_v  = {s1_wr_en, s0_wr_en};
    assign wr_fp_v  = {s1_wr_fp, s0_wr_fp};
    assign wr_reg_v = {s1_wr_reg, s0_wr_reg};
    assign rd_en_a[0] = s0_rd_en;   assign rd_en_a[1] = s1_rd_en;
    assign rd_fp_a[0] = s0_rd_fp;   assign rd_fp_a[1] = s1_rd_fp;
    assign rd_reg_a[0] = s0_rd_reg; assign rd_reg_a[1] = s1_rd_reg;

    // One scoreboard lookup per slot.
    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
        disp_slot_chk #(.REG_W(REG_W), .SRC_N(SRC_N)) u_chk (
            .pending (pending),
            .wr_en   (wr_en_v[g]),
            .wr_fp   (wr_fp_v[g]),
            .wr_reg  (wr_reg_v[g*REG_W +: REG_W]),
            .rd_en   (rd_en_a[g]),
            .rd_fp   (rd_fp_a[g]),
            .rd_reg  (rd_reg_a[g]),
            .sb_hit  (sb_hit[g])
        );
    end

    // Dependencies between the two slots of the pair.
    disp_pair_chk #(.REG_W(REG_W), .SRC_N(SRC_N)) u_pair (
        .old_wr_en  (s0_wr_en),
        .old_wr_fp  (s0_wr_fp),
        .old_wr_reg (s0_wr_reg),
        .yng_wr_en  (s1_wr_en),
        .yng_wr_fp  (s1_wr_fp),
        .yng_wr_reg (s1_wr_reg),
        .yng_rd_en  (s1_rd_en),
        .yng_rd_fp  (s1_rd_fp),
        .yng_rd_reg (s1_rd_reg),
        .raw_dep    (raw_dep),
        .waw_dep    (waw_dep)
    );

    // Pipe selection and in-order grant decision.
    assign fp0 = goes_fp_pipe(s0_cls);
    assign fp1 = goes_fp_pipe(s1_cls);
    assign issue_old   = s0_valid && !stall && !sb_hit[0];
    assign issue_young = issue_old && s1_valid && (fp0 != fp1) &&
                         !sb_hit[1] && !raw_dep && !waw_dep;
    assign int_go   = (issue_old && !fp0) || (issue_young && !fp1);
    assign fp_go    = (issue_old && fp0) || (issue_young && fp1);
    assign consumed = {1'b0, issue_old} + {1'b0, issue_young};

    // Issued floating-point destinations become pending.
    assign mark_en = {issue_young && s1_wr_en && s1_wr_fp,
                      issue_old && s0_wr_en && s0_wr_fp};

    disp_scoreboard #(.REG_W(REG_W), .SET_N(SLOT_N)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (mark_en),
        .set_reg (wr_reg_v),
        .clr_en  (wb_valid),
        .clr_reg (wb_reg),
        .pending (pending)
    );

    // R3
    one_per_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_go && fp_go) || consumed == 2'd2);

    // R4
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_young |-> issue_old);

    // R5
    pair_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_young |-> !raw_dep);

    // R7
    sb_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_old && s0_rd_en[0] && s0_rd_fp[0] |-> !pending[s0_rd_reg[REG_W-1:0]]);

    // R9
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> consumed == 2'd0 && !int_go && !fp_go);
endmodule

// File: tb/sim_dual_dispatch.sv
// Bench for dual_dispatch: directed corners then seeded random pairs,
// checked against a scoreboard model kept in the bench.
module sim_dual_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall = 1'b0;
    logic        v [2];
    logic [1:0]  cls [2];
    logic        wen [2];
    logic        wfp [2];
    logic [4:0]  wreg [2];
    logic [1:0]  ren [2];
    logic [1:0]  rfp [2];
    logic [9:0]  rreg [2];
    logic        wb_valid = 1'b0;
    logic [4:0]  wb_reg = '0;
    logic issue_old, issue_young, int_go, fp_go;
    logic [1:0] consumed;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] mpend = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_dispatch #(.REG_W(RW), .SRC_N(2)) u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .s0_valid(v[0]), .s0_cls(cls[0]), .s0_wr_en(wen[0]), .s0_wr_fp(wfp[0]),
        .s0_wr_reg(wreg[0]), .s0_rd_en(ren[0]), .s0_rd_fp(rfp[0]), .s0_rd_reg(rreg[0]),
        .s1_valid(v[1]), .s1_cls(cls[1]), .s1_wr_en(wen[1]), .s1_wr_fp(wfp[1]),
        .s1_wr_reg(wreg[1]), .s1_rd_en(ren[1]), .s1_rd_fp(rfp[1]), .s1_rd_reg(rreg[1]),
        .wb_valid(wb_valid), .wb_reg(wb_reg),
        .issue_old(issue_old), .issue_young(issue_young),
        .int_go(int_go), .fp_go(fp_go), .consumed(consumed)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_fp(input logic [1:0] c);
        return c >= 2'd2;
    endfunction

    function automatic bit match(input logic fa, input logic [4:0] ra,
                                 input logic fb, input logic [4:0] rb);
        return fa == fb && ra == rb && (fa || ra != 5'd0);
    endfunction

    function automatic bit hit(input int i);
        bit h = wen[i] && wfp[i] && mpend[wreg[i]];
        for (int s = 0; s < 2; s++)
            if (ren[i][s] && rfp[i][s] && mpend[rreg[i][s*5 +: 5]]) h = 1;
        return h;
    endfunction

    function automatic bit pair_dep();
        bit d = wen[1] && match(wfp[0], wreg[0], wfp[1], wreg[1]);
        for (int s = 0; s < 2; s++)
            if (ren[1][s] && match(wfp[0], wreg[0], rfp[1][s], rreg[1][s*5 +: 5])) d = 1;
        return wen[0] && d;
    endfunction

    task automatic clear_slots();
        for (int i = 0; i < 2; i++) begin
            v[i] = 0; cls[i] = 0; wen[i] = 0; wfp[i] = 0; wreg[i] = 0;
            ren[i] = 0; rfp[i] = 0; rreg[i] = 0;
        end
        stall = 0; wb_valid = 0; wb_reg = 0;
    endtask

    task automatic set_slot(input int i, input logic [1:0] c, input logic we, input logic wf,
                            input logic [4:0] wr, input logic re, input logic rf,
                            input logic [4:0] rr);
        v[i] = 1; cls[i] = c; wen[i] = we; wfp[i] = wf; wreg[i] = wr;
        ren[i] = {1'b0, re}; rfp[i] = {1'b0, rf}; rreg[i] = {5'd0, rr};
    endtask

    // Compare outputs with the model, then advance the model at the edge.
    task automatic step();
        bit eo, ey;
        logic [31:0] nxt;
        #1;
        eo = v[0] && !stall && !hit(0);
        ey = eo && v[1] && (is_fp(cls[0]) != is_fp(cls[1])) && !hit(1) && !pair_dep();
        check("R7 R9 old grant", issue_old, eo);
        check("R3 R4 R5 R6 young grant", issue_young, ey);
        check("R2 int_go", int_go, (eo && !is_fp(cls[0])) || (ey && !is_fp(cls[1])));
        check("R2 fp_go", fp_go, (eo && is_fp(cls[0])) || (ey && is_fp(cls[1])));
        check("R10 consumed", consumed, int'(eo) + int'(ey));
        nxt = mpend;
        if (wb_valid) nxt[wb_reg] = 0;
        if (eo && wen[0] && wfp[0]) nxt[wreg[0]] = 1;
        if (ey && wen[1] && wfp[1]) nxt[wreg[1]] = 1;
        @(posedge clk);
        mpend = nxt;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        mpend = '0;
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        clear_slots();
        do_reset();
        // R1: empty slots issue nothing
        step();
        // R1: fresh scoreboard lets fp readers of f5/f6 go
        set_slot(0, 2'd2, 1, 1, 5'd7, 1, 1, 5'd5);
        set_slot(1, 2'd1, 0, 0, 5'd0, 1, 1, 5'd6);
        #1 check("R1 fresh board pair", consumed, 2); step();
        // R3: two integer-pipe, then two fp-pipe
        clear_slots();
        set_slot(0, 2'd0, 1, 0, 5'd1, 0, 0, 5'd0);
        set_slot(1, 2'd1, 1, 0, 5'd2, 0, 0, 5'd0);
        #1 check("R3 int+int", consumed, 1); step();
        set_slot(0, 2'd2, 1, 1, 5'd10, 0, 0, 5'd0);
        set_slot(1, 2'd3, 1, 1, 5'd11, 0, 0, 5'd0);
        #1 check("R3 fp+fp", consumed, 1); step();
        // R7: f7 and f10 are pending now; reader of f7 blocked, young held (R4)
        set_slot(0, 2'd2, 1, 1, 5'd12, 1, 1, 5'd7);
        set_slot(1, 2'd0, 1, 0, 5'd3, 0, 0, 5'd0);
        #1 check("R7 pending read blocks", issue_old, 0);
        check("R4 young held", issue_young, 0); step();
        // R8: writeback of f7 this cycle, reader still blocked, then free
        wb_valid = 1; wb_reg = 5'd7;
        #1 check("R8 clear not yet seen", issue_old, 0); step();
        wb_valid = 0;
        #1 check("R8 clear seen next cycle", consumed, 2); step();
        // R8: mark wins over same-cycle clear of f20
        clear_slots();
        set_slot(0, 2'd1, 1, 1, 5'd20, 0, 0, 5'd0);
        wb_valid = 1; wb_reg = 5'd20;
        step();
        clear_slots();
        set_slot(0, 2'd2, 1, 1, 5'd21, 1, 1, 5'd20);
        #1 check("R8 mark beats clear", issue_old, 0); step();
        // R5: young reads old int dst r4; then r0 exception
        clear_slots();
        set_slot(0, 2'd0, 1, 0, 5'd4, 0, 0, 5'd0);
        set_slot(1, 2'd2, 1, 1, 5'd13, 1, 0, 5'd4);
        #1 check("R5 raw int r4", consumed, 1); step();
        set_slot(0, 2'd0, 1, 0, 5'd0, 0, 0, 5'd0);
        set_slot(1, 2'd2, 1, 1, 5'd14, 1, 0, 5'd0);
        #1 check("R5 r0 never matches", consumed, 2); step();
        // R5: same index in the other file is no dependency
        clear_slots();
        set_slot(0, 2'd0, 1, 0, 5'd9, 0, 0, 5'd0);
        set_slot(1, 2'd2, 1, 1, 5'd15, 1, 1, 5'd9);
        #1 check("R5 file mismatch", consumed, 2); step();
        // R6: both write f16
        clear_slots();
        set_slot(0, 2'd1, 1, 1, 5'd16, 0, 0, 5'd0);
        set_slot(1, 2'd2, 1, 1, 5'd16, 0, 0, 5'd0);
        #1 check("R6 same dst", consumed, 1); step();
        // R9: stall holds a good pair; scoreboard untouched for f17
        clear_slots();
        set_slot(0, 2'd1, 1, 1, 5'd17, 0, 0, 5'd0);
        set_slot(1, 2'd0, 1, 0, 5'd5, 0, 0, 5'd0);
        stall = 1;
        #1 check("R9 stall grants", consumed, 0); step();
        clear_slots();
        set_slot(0, 2'd2, 1, 1, 5'd18, 1, 1, 5'd17);
        #1 check("R9 no mark while stalled", issue_old, 1); step();
        // R1: reset empties the board (f18 pending now)
        clear_slots();
        do_reset();
        set_slot(0, 2'd2, 1, 1, 5'd19, 1, 1, 5'd18);
        #1 check("R1 reset clears pending", issue_old, 1); step();
        // Random phase on an eight-register window
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < 2; i++) begin
                v[i] = ($urandom % 100) < 85;
                cls[i] = 2'($urandom);
                wen[i] = ($urandom % 4) != 0;
                wfp[i] = 1'($urandom);
                wreg[i] = 5'($urandom % 8);
                ren[i] = 2'($urandom);
                rfp[i] = 2'($urandom);
                rreg[i] = {5'($urandom % 8), 5'($urandom % 8)};
            end
            stall = ($urandom % 10) == 0;
            wb_valid = ($urandom % 10) < 4;
            wb_reg = 5'($urandom % 8);
            step();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule